// File: doc/BRIEF.md
# Rotating Interrupt Priority Resolver

This block decides which of a small set of interrupt lines should be presented to the processor right now. It receives three snapshots of controller state: pending requests, per-line masks and lines currently in service. It also receives three mode flags and combines them with a rotation base held in a small register. Priority is circular. The line sitting at the base is the most urgent, and urgency falls off line by line with wrap-around.

A pending, unmasked request is reported only if it is more urgent than the most urgent line already being serviced. Two modes can shrink the in-service set before that comparison. The first drops lines that are currently masked. The second, used only on the primary controller in a cascaded pair, drops the line that carries the secondary controller's output. The decision path is purely combinational, so the outputs follow the inputs within the same cycle. The rotation base register is the only state in the block. A rotate command moves the base so that the line after the named one becomes the most urgent.

Top module: `irq_rank_arbiter`

## Requirements
- R1: A line can win only if its request bit is 1 and its mask bit is 0.
- R2: Rank r (0 = most urgent, N_LINES-1 = least) belongs to line (r + base) mod N_LINES. Of the unmasked pending lines, the one with the smallest rank wins.
- R3: With no unmasked pending request, `irq_o` is 0.
- R4: `irq_o` is 1 only when the winner's rank is strictly smaller than the smallest rank in the effective in-service set. An equal rank (the same line already in service) gives no interrupt. An empty effective in-service set counts as rank N_LINES.
- R5: When `smask_mode` is 1, in-service lines whose mask bit is 1 are removed from the effective in-service set. When it is 0, they stay.
- R6: When `nest_mode` and `is_primary` are both 1, in-service bit CASCADE_LINE (default 2) is removed from the effective in-service set. When either flag is 0, it stays.
- R7: When `irq_o` is 1, `win_line_o` gives the winning line number. When `irq_o` is 0, `win_line_o` is 0.
- R8: `irq_o` and `win_line_o` depend only on the present inputs and the present base, with no register stage. A change on any input is seen before the next clock edge.
- R9: The base resets to 0. On a clock edge with `rot_set` at 1, the base becomes (`rot_line` + 1) mod N_LINES, with 7 wrapping to 0 for eight lines. Without `rot_set`, the base holds its value. The base is visible on `base_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the rotation base register |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_bits | input | N_LINES | Pending request per line |
| mask_bits | input | N_LINES | Mask per line, 1 = blocked |
| svc_bits | input | N_LINES | In-service flag per line |
| smask_mode | input | 1 | Ignore masked in-service lines |
| nest_mode | input | 1 | Ignore the cascade line in service (primary only) |
| is_primary | input | 1 | 1 when this controller is the primary of a cascade |
| rot_set | input | 1 | Load a new rotation base |
| rot_line | input | IDX_W | Line that becomes least urgent after the load |
| base_o | output | IDX_W | Current rotation base |
| irq_o | output | 1 | Interrupt request to the processor |
| win_line_o | output | IDX_W | Winning line number |

## Verification
The bench builds the block with its default of eight lines and CASCADE_LINE 2. At that size, all 256 request patterns can be swept at every one of the eight rotation bases, and every base load, including the wrap from line 7, can be exercised. A second sweep draws pseudo-random mask, in-service and mode combinations at each base and compares the results with an arithmetic model. Directed cases pin down the strict-rank comparison and both in-service filters, with each flag on and off.

// File: rtl/irq_rank_pkg.sv
package irq_rank_pkg;

  // Mode flags that reshape the in-service set before comparison
  typedef struct packed {
    logic smask;
    logic nest;
    logic primary;
  } svc_mode_t;

endpackage

// File: rtl/irq_rank_scan.sv
// Rotates a line vector so that the base line lands at rank 0, then
// returns the smallest occupied rank, or N_LINES when the vector is empty.
module irq_rank_scan #(
  parameter int N_LINES = 8,
  parameter int IDX_W   = $clog2(N_LINES),
  parameter int RANK_W  = IDX_W + 1
) (
  input  logic [N_LINES-1:0] vec_i,
  input  logic [IDX_W-1:0]   base_i,
  output logic [RANK_W-1:0]  rank_o
);

  logic [N_LINES-1:0] by_rank;

  for (genvar k = 0; k < N_LINES; k++) begin : g_rot
    localparam logic [IDX_W-1:0] KOFF = IDX_W'(k);
    logic [IDX_W-1:0] src;
    assign src        = KOFF + base_i;
    assign by_rank[k] = vec_i[src];
  end

  always_comb begin
    rank_o = RANK_W'(N_LINES);
    for (int k = N_LINES - 1; k >= 0; k--) begin
      if (by_rank[k]) rank_o = RANK_W'(k);
    end
  end

endmodule

// File: rtl/irq_svc_filter.sv
// Builds the effective in-service set used for the current-priority rank.
module irq_svc_filter
  import irq_rank_pkg::*;
#(
  parameter int N_LINES      = 8,
  parameter int CASCADE_LINE = 2
) (
  input  logic [N_LINES-1:0] svc_i,
  input  logic [N_LINES-1:0] mask_i,
  input  svc_mode_t          mode_i,
  output logic [N_LINES-1:0] svc_eff_o
);

  logic [N_LINES-1:0] after_mask;
  logic [N_LINES-1:0] cascade_hole;

  assign after_mask = mode_i.smask ? (svc_i & ~mask_i) : svc_i;

  for (genvar k = 0; k < N_LINES; k++) begin : g_hole
    if (k == CASCADE_LINE) begin : g_cas
      assign cascade_hole[k] = mode_i.nest & mode_i.primary;
    end else begin : g_other
      assign cascade_hole[k] = 1'b0;
    end
  end

  assign svc_eff_o = after_mask & ~cascade_hole;

endmodule

// File: rtl/irq_rank_base_reg.sv
// Holds the rotation base; a rotate command makes the line after the
// named one the most urgent.
module irq_rank_base_reg #(
  parameter int N_LINES = 8,
  parameter int IDX_W   = $clog2(N_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en_i,
  input  logic [IDX_W-1:0] set_line_i,
  output logic [IDX_W-1:0] base_q_o
);

  logic [IDX_W-1:0] base_d;
  logic [IDX_W-1:0] base_q;

  always_comb begin
    base_d = base_q;
    if (set_en_i) base_d = set_line_i + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (set_en_i) begin
      base_q <= base_d;
    end
  end

  assign base_q_o = base_q;

endmodule

// File: rtl/irq_win_select.sv
// Strict rank comparison and mapping of the winning rank back to a line.
module irq_win_select #(
  parameter int N_LINES = 8,
  parameter int IDX_W   = $clog2(N_LINES),
  parameter int RANK_W  = IDX_W + 1
) (
  input  logic [RANK_W-1:0] req_rank_i,
  input  logic [RANK_W-1:0] svc_rank_i,
  input  logic [IDX_W-1:0]  base_i,
  output logic              irq_o,
  output logic [IDX_W-1:0]  line_o
);

  logic [IDX_W-1:0] mapped;

  assign mapped = req_rank_i[IDX_W-1:0] + base_i;

  always_comb begin
    irq_o  = 1'b0;
    line_o = '0;
    if (req_rank_i < svc_rank_i) begin
      irq_o  = 1'b1;
      line_o = mapped;
    end
  end

endmodule

// File: rtl/irq_rank_arbiter.sv
module irq_rank_arbiter
  import irq_rank_pkg::*;
#(
  parameter int N_LINES      = 8,
  parameter int CASCADE_LINE = 2,
  parameter int IDX_W        = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] req_bits,
  input  logic [N_LINES-1:0] mask_bits,
  input  logic [N_LINES-1:0] svc_bits,
  input  logic               smask_mode,
  input  logic               nest_mode,
  input  logic               is_primary,
  input  logic               rot_set,
  input  logic [IDX_W-1:0]   rot_line,
  output logic [IDX_W-1:0]   base_o,
  output logic               irq_o,
  output logic [IDX_W-1:0]   win_line_o
);

  localparam int RANK_W = IDX_W + 1;

  logic [IDX_W-1:0]   base;
  logic [N_LINES-1:0] cand;
  logic [N_LINES-1:0] svc_eff;
  logic [RANK_W-1:0]  req_rank;
  logic [RANK_W-1:0]  svc_rank;
  svc_mode_t          mode;

  assign mode = '{smask: smask_mode, nest: nest_mode, primary: is_primary};
  assign cand = req_bits & ~mask_bits;

  irq_rank_base_reg #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_base (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en_i  (rot_set),
    .set_line_i(rot_line),
    .base_q_o  (base)
  );

  irq_svc_filter #(.N_LINES(N_LINES), .CASCADE_LINE(CASCADE_LINE)) u_filt (
    .svc_i    (svc_bits),
    .mask_i   (mask_bits),
    .mode_i   (mode),
    .svc_eff_o(svc_eff)
  );

  irq_rank_scan #(.N_LINES(N_LINES), .IDX_W(IDX_W), .RANK_W(RANK_W)) u_req_scan (
    .vec_i (cand),
    .base_i(base),
    .rank_o(req_rank)
  );

  irq_rank_scan #(.N_LINES(N_LINES), .IDX_W(IDX_W), .RANK_W(RANK_W)) u_svc_scan (
    .vec_i (svc_eff),
    .base_i(base),
    .rank_o(svc_rank)
  );

  irq_win_select #(.N_LINES(N_LINES), .IDX_W(IDX_W), .RANK_W(RANK_W)) u_sel (
    .req_rank_i(req_rank),
    .svc_rank_i(svc_rank),
    .base_i    (base),
    .irq_o     (irq_o),
    .line_o    (win_line_o)
  );

  assign base_o = base;

endmodule

// File: rtl/irq_rank_arbiter_chk.sv
module irq_rank_arbiter_chk #(
  parameter int N_LINES      = 8,
  parameter int CASCADE_LINE = 2,
  parameter int IDX_W        = $clog2(N_LINES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_LINES-1:0] req_bits,
  input logic [N_LINES-1:0] mask_bits,
  input logic [N_LINES-1:0] svc_bits,
  input logic               smask_mode,
  input logic               nest_mode,
  input logic               is_primary,
  input logic               rot_set,
  input logic [IDX_W-1:0]   rot_line,
  input logic [IDX_W-1:0]   base_o,
  input logic               irq_o,
  input logic [IDX_W-1:0]   win_line_o
);

  assert_winner_unmasked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (req_bits[win_line_o] && !mask_bits[win_line_o]));

  assert_empty_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_bits & ~mask_bits) == '0) |-> !irq_o);

  assert_not_in_service_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !smask_mode && !nest_mode) |-> !svc_bits[win_line_o]);

  assert_idle_line_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (win_line_o == '0));

  assert_base_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rot_set |=> (base_o == IDX_W'($past(rot_line) + IDX_W'(1))));

  assert_base_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rot_set |=> $stable(base_o));

endmodule

bind irq_rank_arbiter irq_rank_arbiter_chk #(
  .N_LINES(N_LINES), .CASCADE_LINE(CASCADE_LINE), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_bits(req_bits), .mask_bits(mask_bits),
  .svc_bits(svc_bits), .smask_mode(smask_mode), .nest_mode(nest_mode),
  .is_primary(is_primary), .rot_set(rot_set), .rot_line(rot_line),
  .base_o(base_o), .irq_o(irq_o), .win_line_o(win_line_o)
);

// File: tb/irq_rank_arbiter_tb.sv
`timescale 1ns/1ps
module irq_rank_arbiter_tb;

  localparam int N  = 8;
  localparam int IW = 3;
  localparam int CAS = 2;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  req_bits, mask_bits, svc_bits;
  logic          smask_mode, nest_mode, is_primary;
  logic          rot_set;
  logic [IW-1:0] rot_line;
  logic [IW-1:0] base_o;
  logic          irq_o;
  logic [IW-1:0] win_line_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] seed = 32'h1F2E_3D4C;

  irq_rank_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .req_bits(req_bits), .mask_bits(mask_bits),
    .svc_bits(svc_bits), .smask_mode(smask_mode), .nest_mode(nest_mode),
    .is_primary(is_primary), .rot_set(rot_set), .rot_line(rot_line),
    .base_o(base_o), .irq_o(irq_o), .win_line_o(win_line_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13;
    x ^= x >> 17;
    x ^= x << 5;
    return x;
  endfunction

  // Arithmetic model built from the requirements
  function automatic logic [IW:0] model(
      input logic [N-1:0] rq, input logic [N-1:0] mk, input logic [N-1:0] sv,
      input int b, input logic sm, input logic ns, input logic pr);
    int best = N;
    int cur  = N;
    logic [N-1:0] cand = rq & ~mk;
    logic [N-1:0] eff  = sv;
    if (sm) eff = eff & ~mk;
    if (ns && pr) eff[CAS] = 1'b0;
    for (int r = N - 1; r >= 0; r--) begin
      if (cand[(r + b) % N]) best = r;
      if (eff[(r + b) % N])  cur  = r;
    end
    if (best < cur) return {1'b1, IW'((best + b) % N)};
    return '0;
  endfunction

  task automatic check_val(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_base(input int b);
    @(negedge clk);
    rot_set  = 1'b1;
    rot_line = IW'((b + N - 1) % N);
    @(negedge clk);
    rot_set  = 1'b0;
  endtask

  // Drive between edges and sample 1 ns later, before the next rising edge
  task automatic apply(input string tag, input logic [N-1:0] rq, input logic [N-1:0] mk,
                       input logic [N-1:0] sv, input logic sm, input logic ns,
                       input logic pr);
    logic [IW:0] e;
    @(negedge clk);
    req_bits = rq; mask_bits = mk; svc_bits = sv;
    smask_mode = sm; nest_mode = ns; is_primary = pr;
    #1;
    e = model(rq, mk, sv, int'(base_o), sm, ns, pr);
    check_val(tag, {irq_o, win_line_o}, e);
  endtask

  initial begin
    rst_n = 1'b0;
    req_bits = '0; mask_bits = '0; svc_bits = '0;
    smask_mode = 1'b0; nest_mode = 1'b0; is_primary = 1'b0;
    rot_set = 1'b0; rot_line = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_val("R9 reset base", base_o, 0);
    check_val("R3 reset irq", irq_o, 0);
    check_val("R7 reset line", win_line_o, 0);

    // R2: rotation order
    apply("R2 base0 pick", 8'h84, 8'h00, 8'h00, 0, 0, 0);
    check_val("R2 base0 line", win_line_o, 2);
    set_base(3);
    check_val("R9 load base3", base_o, 3);
    apply("R2 base3 pick", 8'h84, 8'h00, 8'h00, 0, 0, 0);
    check_val("R2 base3 line", win_line_o, 7);
    @(negedge clk);
    check_val("R9 hold base", base_o, 3);
    @(negedge clk);
    rot_set = 1'b1; rot_line = 3'd7;
    @(negedge clk);
    rot_set = 1'b0;
    check_val("R9 wrap to 0", base_o, 0);

    // R1: masked request never wins
    apply("R1 masked", 8'h10, 8'h10, 8'h00, 0, 0, 0);
    check_val("R1 masked irq", irq_o, 0);
    // R4: equal rank is not enough
    apply("R4 equal", 8'h08, 8'h00, 8'h08, 0, 0, 0);
    check_val("R4 equal irq", irq_o, 0);
    apply("R4 beats", 8'h08, 8'h00, 8'h10, 0, 0, 0);
    check_val("R4 beats line", win_line_o, 3);
    // R5: special mask
    apply("R5 on", 8'h20, 8'h01, 8'h01, 1, 0, 0);
    check_val("R5 on irq", irq_o, 1);
    apply("R5 off", 8'h20, 8'h01, 8'h01, 0, 0, 0);
    check_val("R5 off irq", irq_o, 0);
    // R6: cascade line dropped only on the primary with nesting
    apply("R6 primary", 8'h08, 8'h00, 8'h04, 0, 1, 1);
    check_val("R6 primary irq", irq_o, 1);
    apply("R6 secondary", 8'h08, 8'h00, 8'h04, 0, 1, 0);
    check_val("R6 secondary irq", irq_o, 0);
    apply("R6 nest off", 8'h08, 8'h00, 8'h04, 0, 0, 1);
    check_val("R6 nest off irq", irq_o, 0);

    // R2 R3 R7 R8: every request pattern at every base
    for (int b = 0; b < N; b++) begin
      set_base(b);
      check_val("R9 sweep base", base_o, b);
      for (int rq = 0; rq < 256; rq++)
        apply("R2 sweep", N'(rq), 8'h00, 8'h00, 0, 0, 0);
    end

    // R1 R4 R5 R6 R8: pseudo-random state and modes at every base
    for (int b = 0; b < N; b++) begin
      set_base(b);
      for (int i = 0; i < 400; i++) begin
        seed = next_rand(seed);
        apply("R4 random", seed[7:0], seed[15:8] & seed[31:24], seed[23:16] & seed[30:23],
              seed[0], seed[9], seed[17]);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule